// File: doc/BRIEF.md
# Demodulated Data Packet Framer

This block takes the bit stream coming out of a demodulator, one bit per strobe, and turns it into framed byte records for a downstream network stage. Bits are assembled into bytes with the earliest bit in the most significant position. Complete bytes wait in an on-chip queue until a frame is released, and a byte that is still being assembled is never sent.

A frame leaves as a byte stream with valid, last and ready signals. It starts with a 16-byte header followed by the payload. The header holds the payload length, a running frame number, four zero bytes and a 64-bit time tag. The time tag is the one present when the frame's first payload byte was queued. A frame is released as soon as a full payload's worth of bytes is pending. It is also released when a timeout has elapsed since the previous release and at least one byte is pending. A partly filled frame can therefore never wait forever.

The payload size limit and the timeout are parameters. The queue holds two full payloads. When the queue is full, incoming bits are discarded and a sticky flag is raised.

Top module: `demod_frame_packer`

## Requirements
- R1: Bits are packed so that the first bit received becomes bit 7 of its byte. A byte enters the queue only once all 8 of its bits have arrived, and a partial byte stays held until completed.
- R2: Every frame begins with 16 header bytes, numbered from 0 as they are sent. Bytes 0-1 hold the payload length and bytes 2-3 the frame number, each most significant byte first. Bytes 4-7 are zero. Bytes 8-15 hold the 64-bit time tag, most significant byte first.
- R3: The length field counts payload bytes only and lies in 1..PAYLOAD_MAX. A frame is 16 plus length bytes, and `out_last` is high on its final byte only.
- R4: The frame number is 0 for the first frame after reset and rises by 1 (modulo 65536) for each later frame.
- R5: The time tag of a frame equals `time_tag` in the cycle the last bit of that frame's first payload byte was accepted.
- R6: When PAYLOAD_MAX bytes are pending and no frame is being sent, a frame of exactly PAYLOAD_MAX bytes is released. Bytes queued after that moment belong to the following frame.
- R7: When TIMEOUT_CYCLES cycles have passed since the previous release (or reset), at least one byte is pending and no frame is being sent, a frame carrying all pending bytes is released. No frame is released with fewer than PAYLOAD_MAX bytes before the timeout.
- R8: The queue holds 2*PAYLOAD_MAX bytes. A bit arriving while the queue is full is discarded and sets `overflow`, which stays high until reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: After reset, `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Strobe marking a demodulated bit |
| bit_data | input | 1 | Demodulated bit value |
| time_tag | input | 64 | Current time tag |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte present |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| overflow | output | 1 | Sticky flag: bits were discarded |

## Verification
The properties make no assumption about `out_ready`: it may drop on any cycle, including in the middle of the header. The properties also accept bits on any cycle, even back to back. The one thing taken for granted is that `time_tag` is a plain input whose value needs no relation to earlier cycles. The stimulus keeps to this by stalling the output in a repeating pattern that lands on both header and payload bytes. It sends bits on consecutive cycles, fills the queue with the output held off, and splits a byte across a timeout release so that packer state must persist.

// File: rtl/fp_pkg.sv
package fp_pkg;
    localparam int HDR_BYTES = 16;

    // Header byte selector: length, frame number, zero pad, time tag.
    function automatic logic [7:0] hdr_byte(input logic [15:0] len,
                                            input logic [15:0] seq,
                                            input logic [63:0] ts,
                                            input logic [3:0]  i);
        logic [7:0] b;
        case (i)
            4'd0:    b = len[15:8];
            4'd1:    b = len[7:0];
            4'd2:    b = seq[15:8];
            4'd3:    b = seq[7:0];
            4'd4, 4'd5, 4'd6, 4'd7: b = 8'h00;
            default: b = ts[8*(4'd15 - i) +: 8];
        endcase
        return b;
    endfunction
endpackage

// File: rtl/fp_bit_packer.sv
module fp_bit_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid_i,
    input  logic       bit_i,
    input  logic       full_i,
    output logic       push_o,
    output logic [7:0] byte_o,
    output logic       ovf_o
);
    typedef struct packed {
        logic [2:0] cnt;
        logic [6:0] sh;
        logic       ovf;
    } pk_t;

    pk_t q, d;
    logic accept;

    always_comb begin
        d      = q;
        accept = bit_valid_i && !full_i;
        push_o = accept && (q.cnt == 3'd7);
        byte_o = {q.sh, bit_i};
        if (accept) begin
            d.cnt = q.cnt + 3'd1;
            d.sh  = {q.sh[5:0], bit_i};
        end
        if (bit_valid_i && full_i) d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ovf_o = q.ovf;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf);
endmodule

// File: rtl/fp_byte_queue.sv
module fp_byte_queue #(
    parameter int DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [7:0] data_i,
    input  logic       pop_i,
    output logic [7:0] head_o,
    output logic       full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_N = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } qs_t;

    qs_t q, d;
    logic [7:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push_i) d.wr = (q.wr == LAST_P) ? '0 : q.wr + 1'b1;
        if (pop_i)  d.rd = (q.rd == LAST_P) ? '0 : q.rd + 1'b1;
        d.cnt = q.cnt + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[q.wr] <= data_i;
    end

    assign head_o = mem[q.rd];
    assign full_o = (q.cnt == FULL_N);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (q.cnt != FULL_N));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (q.cnt != '0));
endmodule

// File: rtl/fp_frame_ctrl.sv
module fp_frame_ctrl
    import fp_pkg::*;
#(
    parameter int PAYLOAD_MAX    = 1024,
    parameter int TIMEOUT_CYCLES = 62_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_i,
    input  logic [63:0] time_tag_i,
    input  logic [7:0]  head_i,
    input  logic        out_ready_i,
    output logic        pop_o,
    output logic [7:0]  out_data_o,
    output logic        out_valid_o,
    output logic        out_last_o
);
    localparam int LW = $clog2(PAYLOAD_MAX + 1);
    localparam int PW = $clog2(2 * PAYLOAD_MAX + 1);
    localparam int IW = $clog2(HDR_BYTES + PAYLOAD_MAX);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [PW-1:0] MAX_P = PW'(PAYLOAD_MAX);
    localparam logic [TW-1:0] TO_P  = TW'(TIMEOUT_CYCLES);
    localparam logic [IW-1:0] HDR_I = IW'(HDR_BYTES);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] len;
        logic [15:0]   frm_seq;
        logic [63:0]   frm_ts;
        logic [IW-1:0] idx;
        logic [15:0]   seq;
        logic [PW-1:0] pend;
        logic [63:0]   ts_a;
        logic [63:0]   ts_b;
        logic [TW-1:0] timer;
    } fc_t;

    fc_t q, d;
    logic          trig;
    logic [PW-1:0] take, pend1;

    always_comb begin
        d     = q;
        trig  = !q.busy && (q.pend >= MAX_P || (q.pend != '0 && q.timer >= TO_P));
        take  = (q.pend >= MAX_P) ? MAX_P : q.pend;
        pend1 = trig ? q.pend - take : q.pend;
        d.ts_a = trig ? q.ts_b : q.ts_a;
        if (push_i) begin
            if (pend1 == '0)   d.ts_a = time_tag_i;
            if (pend1 == MAX_P) d.ts_b = time_tag_i;
        end
        d.pend = pend1 + PW'(push_i);

        out_valid_o = q.busy;
        out_last_o  = q.busy && (q.idx == HDR_I + IW'(q.len) - 1'b1);
        out_data_o  = (q.idx < HDR_I) ? hdr_byte(16'(q.len), q.frm_seq, q.frm_ts, q.idx[3:0])
                                      : head_i;
        pop_o       = q.busy && out_ready_i && (q.idx >= HDR_I);

        if (trig) begin
            d.busy    = 1'b1;
            d.len     = LW'(take);
            d.frm_seq = q.seq;
            d.frm_ts  = q.ts_a;
            d.seq     = q.seq + 16'd1;
            d.idx     = '0;
            d.timer   = '0;
        end else if (q.timer < TO_P) begin
            d.timer = q.timer + 1'b1;
        end

        if (q.busy && out_ready_i) begin
            if (out_last_o) d.busy = 1'b0;
            else            d.idx  = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.len != '0 && q.len <= LW'(PAYLOAD_MAX)));
    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= PW'(2 * PAYLOAD_MAX));
endmodule

// File: rtl/demod_frame_packer.sv
module demod_frame_packer #(
    parameter int PAYLOAD_MAX    = 1024,
    parameter int TIMEOUT_CYCLES = 62_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_valid,
    input  logic        bit_data,
    input  logic [63:0] time_tag,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_last,
    input  logic        out_ready,
    output logic        overflow
);
    localparam int DEPTH = 2 * PAYLOAD_MAX;

    logic       push, pop, full;
    logic [7:0] pk_byte, head;

    fp_bit_packer u_pack (
        .clk(clk), .rst_n(rst_n),
        .bit_valid_i(bit_valid), .bit_i(bit_data), .full_i(full),
        .push_o(push), .byte_o(pk_byte), .ovf_o(overflow)
    );

    fp_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .data_i(pk_byte), .pop_i(pop),
        .head_o(head), .full_o(full)
    );

    fp_frame_ctrl #(.PAYLOAD_MAX(PAYLOAD_MAX), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .time_tag_i(time_tag), .head_i(head),
        .out_ready_i(out_ready), .pop_o(pop),
        .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last)
    );
endmodule

// File: tb/test_demod_frame_packer.sv
module test_demod_frame_packer;
    localparam int MAXP = 8;
    localparam int TO   = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic [63:0] time_tag = '0;
    logic [7:0]  out_data;
    logic        out_valid, out_last;
    logic        out_ready = 1'b0;
    logic        overflow;

    demod_frame_packer #(.PAYLOAD_MAX(MAXP), .TIMEOUT_CYCLES(TO)) i_demod_frame_packer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .time_tag(time_tag), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .out_ready(out_ready), .overflow(overflow)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    logic [63:0] tag = 64'hA500_0000_0000_1000;
    logic [7:0]  sent_data [0:255];
    logic [63:0] sent_tag  [0:255];
    int nsent = 0, fidx = 0;
    logic [7:0] rec [0:63];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_bits(input logic [7:0] v, input int from, input int to);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = v[7 - i];
            time_tag  = tag;
            if (i == 7) begin
                sent_data[nsent] = v;
                sent_tag[nsent]  = tag;
                nsent++;
            end
            tag = tag + 64'd3;
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        push_bits(v, 0, 8);
    endtask

    // Collect one frame with a repeating stall, check header and payload.
    task automatic get_frame(input int exp_len, input int exp_seq, input string req, input int limit);
        int n = 0, w = 0, cyc = 0;
        logic hold = 1'b0, done = 1'b0, hl;
        logic [7:0] hd;
        while (!out_valid && w < limit) begin
            @(negedge clk);
            w++;
        end
        chk({req, " frame released"}, {63'd0, out_valid}, 64'd1);
        if (!out_valid) return;
        while (!done) begin
            if (cyc > 0) @(negedge clk);
            if (hold) begin
                chk("R9 hold valid", {63'd0, out_valid}, 64'd1);
                chk("R9 hold data", {56'd0, out_data}, {56'd0, hd});
                chk("R9 hold last", {63'd0, out_last}, {63'd0, hl});
                hold = 1'b0;
            end
            out_ready = (cyc % 3) != 2;
            cyc++;
            if (!out_valid || n > 60) begin
                chk({req, " valid mid-frame"}, {63'd0, out_valid}, 64'd1);
                done = 1'b1;
            end else if (out_ready) begin
                rec[n] = out_data;
                n++;
                if (out_last) done = 1'b1;
            end else begin
                hold = 1'b1;
                hd = out_data;
                hl = out_last;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk("R3 frame size", n, 16 + exp_len);
        chk("R2 length field", {rec[0], rec[1]}, exp_len);
        chk("R4 frame number", {rec[2], rec[3]}, exp_seq);
        chk("R2 zero pad", {rec[4], rec[5], rec[6], rec[7]}, 64'd0);
        chk("R5 time tag", {rec[8], rec[9], rec[10], rec[11], rec[12], rec[13], rec[14], rec[15]},
            sent_tag[fidx]);
        for (int k = 0; k < exp_len && 16 + k < n; k++)
            chk("R1 payload byte", {56'd0, rec[16 + k]}, {56'd0, sent_data[fidx + k]});
        fidx = fidx + exp_len;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R10 overflow after reset", {63'd0, overflow}, 64'd0);
    endtask

    task automatic t_size_trigger();
        logic [7:0] v [0:7] = '{8'h80, 8'h01, 8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h5A, 8'hC3};
        for (int i = 0; i < 8; i++) send_byte(v[i]);
        get_frame(MAXP, 0, "R6", 20);
    endtask

    task automatic t_split_and_timeout();
        for (int i = 0; i < 10; i++) send_byte(8'(i * 29 + 7));
        get_frame(MAXP, 1, "R6", 20);
        chk("R7 no early release", {63'd0, out_valid}, 64'd0);
        get_frame(2, 2, "R7", TO + 100);
    endtask

    task automatic t_partial_byte();
        send_byte(8'h96);
        send_byte(8'h69);
        push_bits(8'hB7, 0, 5);
        repeat (10) @(negedge clk);
        chk("R7 waits for timeout", {63'd0, out_valid}, 64'd0);
        get_frame(2, 3, "R1 partial held", TO + 100);
        push_bits(8'hB7, 5, 8);
        get_frame(1, 4, "R1 partial completed", TO + 100);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 17; i++) send_byte(8'(8'hE0 + i));
        chk("R8 overflow set", {63'd0, overflow}, 64'd1);
        get_frame(MAXP, 5, "R8 first", 20);
        get_frame(MAXP, 6, "R8 second", 20);
        repeat (TO + 50) @(negedge clk);
        chk("R8 dropped byte not framed", {63'd0, out_valid}, 64'd0);
        chk("R8 overflow sticky", {63'd0, overflow}, 64'd1);
        fidx = nsent;
        do_reset();
        chk("R10 overflow cleared", {63'd0, overflow}, 64'd0);
        send_byte(8'h4D);
        get_frame(1, 0, "R4 restart after reset", TO + 100);
    endtask

    initial begin
        t_reset();
        t_size_trigger();
        t_split_and_timeout();
        t_partial_byte();
        t_overflow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule